// File: doc/BRIEF.md
# Three-Bus Processor Datapath

This block is the datapath of a small processor. Two read ports of a register file drive buses A and B. An ALU combines the two operands and drives bus C. In the same clock cycle, a write port stores bus C into any register. The ALU can also copy either operand to bus C unchanged. An operand multiplexer on the ALU input can put a fixed step of 4 in place of the bus B value. Software-visible addresses, such as those of a load-multiple or store-multiple loop, can then advance by 4 without a spare register.

The program counter has its own incrementer, so it can advance by 4 in the same cycle that the ALU is doing other work. Instead of advancing, the program counter can load bus C. Every control input comes from a control unit outside this block, one cycle's worth of controls at a time. Register selects, the ALU function and the operand-mux select shape the buses in the same cycle. The write enable and the program-counter controls take effect at the next rising clock edge.

Top module: `tribus_datapath`

## Requirements
- R1: While rst_n is low, all eight registers and the program counter are cleared to 0. Reads on both buses then return 0 for every select.
- R2: bus_a shows the register chosen by rd_a_sel, and bus_b shows the register chosen by rd_b_sel. Both follow their selects in the same cycle, with no clock edge needed.
- R3: When wr_en is high at a rising edge, the register chosen by wr_sel takes the bus_c value of that cycle. When wr_en is low, no register changes.
- R4: When the register being written is also being read in the same cycle, the read bus shows the value it held before that edge.
- R5: The alu_fn codes 0 ADD, 1 SUB (A minus B), 2 AND, 3 OR and 4 XOR put that 32-bit result on bus_c. Addition and subtraction wrap modulo 2^32.
- R6: alu_fn 5 copies the A operand to bus_c, and alu_fn 6 copies the B operand (after the operand mux) to bus_c.
- R7: alu_fn 7 is reserved and drives bus_c to 0.
- R8: When b_src is 1, the ALU B operand is the constant 4 instead of bus_b. bus_b itself still shows the selected register.
- R9: When pc_we is 1 and pc_src is 0 at a rising edge, pc becomes pc + 4, wrapping modulo 2^32.
- R10: When pc_we is 1 and pc_src is 1 at a rising edge, pc takes the bus_c value of that cycle.
- R11: When pc_we is 0, pc keeps its value.
- R12: Register 0 is an ordinary register: it can be written and read back like the other seven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 3 | Register driven onto bus A |
| rd_b_sel | input | 3 | Register driven onto bus B |
| wr_sel | input | 3 | Register that captures bus C |
| wr_en | input | 1 | Write enable for the bus C write port |
| alu_fn | input | 3 | ALU function code |
| b_src | input | 1 | ALU B operand: 0 bus B, 1 constant 4 |
| pc_src | input | 1 | PC next value: 0 incrementer, 1 bus C |
| pc_we | input | 1 | PC update enable |
| bus_a | output | 32 | Bus A value |
| bus_b | output | 32 | Bus B value |
| bus_c | output | 32 | Bus C value (ALU result) |
| pc | output | 32 | Program counter |

## Verification
The read buses and bus C depend on the selects, the function code and the operand mux through logic alone. The bench therefore checks them 1 ns after it drives new controls on the falling edge, in the same cycle. Register writes and program-counter updates land at the next rising edge. The bench applies them to its model at that edge and checks them 1 ns later: the program counter directly, and the registers through the read buses in the cycles that follow. The read-during-write case is checked before the edge, so the old value must still appear on the bus.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
    localparam int DATA_W  = 32;
    localparam int REG_CNT = 8;
    localparam int STEP    = 4;

    typedef enum logic [2:0] {
        FN_ADD    = 3'd0,
        FN_SUB    = 3'd1,
        FN_AND    = 3'd2,
        FN_OR     = 3'd3,
        FN_XOR    = 3'd4,
        FN_PASS_A = 3'd5,
        FN_PASS_B = 3'd6,
        FN_RSVD   = 3'd7
    } alu_fn_t;
endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
    parameter int WIDTH = tribus_pkg::DATA_W,
    parameter int NREG  = tribus_pkg::REG_CNT,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_sel,
    input  logic [AW-1:0]    rd_b_sel,
    input  logic [AW-1:0]    wr_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b
);
    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (wr_sel == AW'(i))) begin
                st_d.regs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // reads come from the registered state, so a same-cycle write is not seen
    assign rd_a = st_q.regs[rd_a_sel];
    assign rd_b = st_q.regs[rd_b_sel];

    for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
        // R3
        reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == AW'(g)) |=> (st_q.regs[g] == $past(wr_data)));
        // R3
        reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == AW'(g)) |=> $stable(st_q.regs[g]));
    end
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int WIDTH = tribus_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       fn,
    output logic [WIDTH-1:0] result
);
    alu_fn_t fn_e;
    assign fn_e = alu_fn_t'(fn);

    always_comb begin
        unique case (fn_e)
            FN_ADD:    result = op_a + op_b;
            FN_SUB:    result = op_a - op_b;
            FN_AND:    result = op_a & op_b;
            FN_OR:     result = op_a | op_b;
            FN_XOR:    result = op_a ^ op_b;
            FN_PASS_A: result = op_a;
            FN_PASS_B: result = op_b;
            default:   result = '0;
        endcase
    end

    // R5
    always_comb begin
        if (fn_e == FN_SUB) begin
            sub_inverse_chk: assert (result + op_b == op_a);
        end
    end
endmodule

// File: rtl/tribus_pc_unit.sv
module tribus_pc_unit #(
    parameter int WIDTH = tribus_pkg::DATA_W,
    parameter int STEP  = tribus_pkg::STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_we,
    input  logic             pc_src,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] pc
);
    typedef struct packed {
        logic [WIDTH-1:0] pc;
    } pc_state_t;

    pc_state_t        st_d, st_q;
    logic [WIDTH-1:0] inc_val;

    assign inc_val = st_q.pc + WIDTH'(STEP);

    always_comb begin
        st_d = st_q;
        if (pc_we) begin
            st_d.pc = pc_src ? load_val : inc_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !pc_src) |=> (st_q.pc - $past(st_q.pc) == WIDTH'(STEP)));
    // R10
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src) |=> (st_q.pc == $past(load_val)));
    // R11
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(st_q.pc));
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
    import tribus_pkg::*;
#(
    parameter int WIDTH = tribus_pkg::DATA_W,
    parameter int NREG  = tribus_pkg::REG_CNT,
    parameter int STEP  = tribus_pkg::STEP,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_sel,
    input  logic [AW-1:0]    rd_b_sel,
    input  logic [AW-1:0]    wr_sel,
    input  logic             wr_en,
    input  logic [2:0]       alu_fn,
    input  logic             b_src,
    input  logic             pc_src,
    input  logic             pc_we,
    output logic [WIDTH-1:0] bus_a,
    output logic [WIDTH-1:0] bus_b,
    output logic [WIDTH-1:0] bus_c,
    output logic [WIDTH-1:0] pc
);
    logic [WIDTH-1:0] alu_b;

    tribus_regfile #(.WIDTH(WIDTH), .NREG(NREG)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_sel (rd_a_sel),
        .rd_b_sel (rd_b_sel),
        .wr_sel   (wr_sel),
        .wr_en    (wr_en),
        .wr_data  (bus_c),
        .rd_a     (bus_a),
        .rd_b     (bus_b)
    );

    // operand mux: fixed step replaces the bus B value
    assign alu_b = b_src ? WIDTH'(STEP) : bus_b;

    tribus_alu #(.WIDTH(WIDTH)) u_alu (
        .op_a   (bus_a),
        .op_b   (alu_b),
        .fn     (alu_fn),
        .result (bus_c)
    );

    tribus_pc_unit #(.WIDTH(WIDTH), .STEP(STEP)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_we    (pc_we),
        .pc_src   (pc_src),
        .load_val (bus_c),
        .pc       (pc)
    );

    // R8
    always_comb begin
        if (rst_n && b_src && alu_fn == FN_ADD) begin
            step_const_chk: assert (bus_c - bus_a == WIDTH'(STEP));
        end
    end
endmodule

// File: tb/tribus_datapath_bench.sv
module tribus_datapath_bench;
    import tribus_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0, alu_fn = '0;
    logic        wr_en = 1'b0, b_src = 1'b0, pc_src = 1'b0, pc_we = 1'b0;
    logic [31:0] bus_a, bus_b, bus_c, pc;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_regs [8];
    logic [31:0] m_pc;

    always #5 clk = ~clk;

    tribus_datapath u_tribus_datapath (
        .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
        .wr_sel(wr_sel), .wr_en(wr_en), .alu_fn(alu_fn), .b_src(b_src),
        .pc_src(pc_src), .pc_we(pc_we), .bus_a(bus_a), .bus_b(bus_b),
        .bus_c(bus_c), .pc(pc)
    );

    function automatic logic [31:0] alu_ref(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] f);
        case (f)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a;
            3'd6: return b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string fn_tag(input logic [2:0] f, input logic bs);
        if (bs) return "R8";
        if (f <= 3'd4) return "R5";
        if (f <= 3'd6) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check combinational buses, then apply the edge
    task automatic cycle(input logic [2:0] a, input logic [2:0] b, input logic [2:0] w,
                         input logic we, input logic [2:0] f, input logic bs,
                         input logic ps, input logic pwe, input string rd_tag);
        logic [31:0] exp_c;
        @(negedge clk);
        rd_a_sel = a; rd_b_sel = b; wr_sel = w; wr_en = we;
        alu_fn = f; b_src = bs; pc_src = ps; pc_we = pwe;
        #1;
        check(rd_tag, bus_a, m_regs[a]);
        check(rd_tag, bus_b, m_regs[b]);
        exp_c = alu_ref(m_regs[a], bs ? 32'd4 : m_regs[b], f);
        check(fn_tag(f, bs), bus_c, exp_c);
        @(posedge clk);
        if (we) m_regs[w] = exp_c;
        if (pwe) m_pc = ps ? exp_c : m_pc + 32'd4;
        #1;
        check(!pwe ? "R11" : (ps ? "R10" : "R9"), pc, m_pc);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_pc = '0;
        #3;
        // R1: values while reset is held
        for (int i = 0; i < 8; i++) begin
            rd_a_sel = 3'(i); rd_b_sel = 3'(7 - i);
            #1;
            check("R1", bus_a, 32'd0);
            check("R1", bus_b, 32'd0);
        end
        check("R1", pc, 32'd0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: build -4 in register 0 (0 - 4) and read it back
        cycle(3'd0, 3'd0, 3'd0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, "R2");
        cycle(3'd0, 3'd1, 3'd2, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, "R12");
        check("R12", bus_a, 32'hFFFF_FFFC);
        // R10: load pc from bus C (pass register 0 = FFFFFFFC)
        cycle(3'd0, 3'd1, 3'd1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, "R2");
        check("R10", pc, 32'hFFFF_FFFC);
        // R9: wrap past 2^32
        cycle(3'd1, 3'd2, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R2");
        check("R9", pc, 32'd0);
        // R4: write register 0 while reading it, bus must keep old value
        @(negedge clk);
        rd_a_sel = 3'd0; rd_b_sel = 3'd0; wr_sel = 3'd0; wr_en = 1'b1;
        alu_fn = 3'd0; b_src = 1'b1; pc_we = 1'b0; pc_src = 1'b0;
        #1;
        check("R4", bus_a, 32'hFFFF_FFFC);
        @(posedge clk);
        m_regs[0] = 32'd0;
        #1;
        check("R4", bus_a, 32'd0);
        // R7: reserved code with nonzero operands
        cycle(3'd0, 3'd0, 3'd3, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, "R2");
        cycle(3'd3, 3'd3, 3'd4, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, "R7");
        // R3: write disabled keeps register 4 at zero
        cycle(3'd3, 3'd3, 3'd4, 1'b0, 3'd5, 1'b0, 1'b0, 1'b0, "R3");
        cycle(3'd4, 3'd3, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
        check("R3", bus_a, 32'd0);

        // random mixed stimulus, seed fixed
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[2:0], r[5:3], r[8:6], r[9] | r[10], r[13:11], r[14] & r[15],
                  r[16] & r[17], r[18], (r[9] | r[10]) ? "R3" : "R2");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule